// File: doc/BRIEF.md
# Double-Buffered 8-Bit PWM Timer

The block is an 8-bit pulse-width modulation timer. A free-running up-counter advances on a prescaled count enable and wraps every 256 counts. A toggle flip-flop flips when the counter matches the active duty value and flips again when the counter wraps. The output pin carries the inverse of that flip-flop, so it is high from count 0 up to and including the duty count and low for the rest of the period.

Software writes the duty value into a holding register through a write strobe. The holding value moves into the active compare register only when a period completes, so the duty can be rewritten at any time without a glitch. Setting the run bit also copies the holding value into the active register, which is how the first value is loaded. One control write sets the run bit and the prescale select together. Clearing the run bit stops and clears the counter, and the output idles high. An overflow interrupt pulse lasts one system clock.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset, pwm_o is 1 and ovf_irq_o is 0. The counter is stopped.
- R2: While running with an active duty d below 255, pwm_o is 1 while the counter holds a value from 0 to d and 0 while it holds d+1 to 255. One period is 256 counts, and after a start the counter begins at 0.
- R3: With an active duty of 255, the match and the wrap fall on the same count and cancel, so pwm_o stays 1 for the whole period.
- R4: With an active duty of 0, pwm_o is 1 for exactly one count per period and makes two transitions in every period.
- R5: ovf_irq_o is a one-system-clock pulse on the last system clock of count 255 and is 0 at all other times.
- R6: ctrl_div_i selects the count rate: 0 gives one count per system clock, 1 gives one count per 2 clocks, and 2 or 3 give one count per 4 clocks. The value is latched on a control write.
- R7: A duty write made during a period does not change that period. The new value applies from the next period.
- R8: A control write with ctrl_run_i=1 while stopped copies the holding value into the active register. Duty writes made while stopped leave pwm_o at 1.
- R9: A control write with ctrl_run_i=0 clears the counter and the flip-flop at the next clock edge. pwm_o is then 1 and ovf_irq_o stays 0 until the timer is restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| duty_we_i | input | 1 | Write strobe for the duty holding register |
| duty_i | input | 8 | Duty value to write |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| ctrl_run_i | input | 1 | Run bit: 1 starts the timer, 0 stops and clears it |
| ctrl_div_i | input | 2 | Prescale select (0: /1, 1: /2, 2 and 3: /4) |
| pwm_o | output | 1 | PWM output, the inverse of the toggle flip-flop |
| ovf_irq_o | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a prescale range up to divide-by-4. With these values a whole period fits in at most 1024 system clocks, so every prescale select can be compared cycle by cycle over complete periods. This includes the duty values 0 and 255, where the match and the wrap are adjacent or coincide. Duty changes in mid-period, stopping with the output low, and restarting from a value written while stopped are also checked across period boundaries.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PRE_W = 2;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_2  = 2'd1,
    DIV_4  = 2'd2,
    DIV_4B = 2'd3
  } div_sel_e;

  function automatic int unsigned div_shift(div_sel_e s);
    case (s)
      DIV_1:   return 0;
      DIV_2:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     clr_i,
  input  div_sel_e sel_i,
  output logic     tick_o
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask = PW'((32'd1 << div_shift(sel_i)) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i || !run_i)   pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != DIV_1) |=> (!tick_o || sel_i == DIV_1)); // R6
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         start_i,
  input  logic         wrap_i,
  input  logic         run_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (we_i) hold_q <= wdata_i;
  end

  // active stage only moves at start or period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 act_q <= '0;
    else if (start_i || wrap_i)  act_q <= hold_q;
  end

  assign active_o = act_q;

  AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i && !start_i) |=> $stable(act_q)); // R7
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (act_q == $past(hold_q))); // R8
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         stop_i,
  input  logic         tick_i,
  input  logic [W-1:0] duty_i,
  output logic         wrap_o,
  output logic         pwm_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         tff_q;
  logic         step;
  logic         hit_match;
  logic         hit_top;

  assign step      = tick_i && run_i && !stop_i;
  assign hit_match = (cnt_q == duty_i);
  assign hit_top   = (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tff_q <= 1'b0;
    end else if (stop_i || !run_i) begin
      cnt_q <= '0;
      tff_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      // match and wrap on one count cancel
      tff_q <= tff_q ^ hit_match ^ hit_top;
    end
  end

  assign wrap_o = step && hit_top;
  assign pwm_o  = ~tff_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0)); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (cnt_q == '0 && pwm_o)); // R9
  AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (pwm_o && !wrap_o)); // R9
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned PW = PRE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         duty_we_i,
  input  logic [W-1:0] duty_i,
  input  logic         ctrl_we_i,
  input  logic         ctrl_run_i,
  input  logic [1:0]   ctrl_div_i,
  output logic         pwm_o,
  output logic         ovf_irq_o
);
  logic     run_q;
  div_sel_e sel_q;
  logic     start_p;
  logic     stop_p;
  logic     tick;
  logic     wrap;
  logic [W-1:0] duty_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= DIV_1;
    end else if (ctrl_we_i) begin
      run_q <= ctrl_run_i;
      sel_q <= div_sel_e'(ctrl_div_i);
    end
  end

  assign start_p = ctrl_we_i && ctrl_run_i && !run_q;
  assign stop_p  = ctrl_we_i && !ctrl_run_i;

  pwm_prescaler #(.PW(PW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .clr_i  (stop_p),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  pwm_duty_buf #(.W(W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (duty_we_i),
    .wdata_i  (duty_i),
    .start_i  (start_p),
    .wrap_i   (wrap),
    .run_i    (run_q),
    .active_o (duty_act)
  );

  pwm_core #(.W(W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .stop_i (stop_p),
    .tick_i (tick),
    .duty_i (duty_act),
    .wrap_o (wrap),
    .pwm_o  (pwm_o)
  );

  assign ovf_irq_o = wrap;

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_p) |=> (pwm_o && !ovf_irq_o)); // R1
endmodule

// File: tb/tb_pwm_dbuf_timer.sv
module tb_pwm_dbuf_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  pwm;
    logic  irq;
    string req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       duty_we_i = 1'b0;
  logic [7:0] duty_i = '0;
  logic       ctrl_we_i = 1'b0;
  logic       ctrl_run_i = 1'b0;
  logic [1:0] ctrl_div_i = '0;
  logic       pwm_o;
  logic       ovf_irq_o;

  int   total = 0;
  int   bad = 0;
  int   edges = 0;
  logic last_pwm = 1'b1;
  bit   mon_first = 1'b1;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_dbuf_timer dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .duty_we_i  (duty_we_i),
    .duty_i     (duty_i),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_run_i (ctrl_run_i),
    .ctrl_div_i (ctrl_div_i),
    .pwm_o      (pwm_o),
    .ovf_irq_o  (ovf_irq_o)
  );

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per system clock
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (!mon_first && pwm_o !== last_pwm) edges++;
      mon_first = 1'b0;
      last_pwm = pwm_o;
      check(e.req, pwm_o, e.pwm, "pwm_o");
      check(e.req, ovf_irq_o, e.irq, "ovf_irq_o");
    end
  end

  // driver: expected output for n cycles after a start edge
  task automatic push_window(int d0, int d1, int sel, int n, string req);
    int nd;
    nd = 1 << ((sel > 2) ? 2 : sel);
    for (int j = 0; j < n; j++) begin
      exp_t e;
      int c, p, d;
      c = (j / nd) % 256;
      p = (j / nd) / 256;
      d = (p == 0) ? d0 : d1;
      e.pwm = (d == 255) ? 1'b1 : (c <= d);
      e.irq = ((j % nd) == nd - 1) && (c == 255);
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic start(bit wr, int d, int sel);
    if (wr) begin
      @(posedge clk_i); #1;
      duty_we_i = 1'b1; duty_i = 8'(d);
      @(posedge clk_i); #1;
      duty_we_i = 1'b0;
    end else begin
      @(posedge clk_i); #1;
    end
    ctrl_we_i = 1'b1; ctrl_run_i = 1'b1; ctrl_div_i = 2'(sel);
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0;
  endtask

  task automatic stop();
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b1; ctrl_run_i = 1'b0;
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk_i); #1;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk_i);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", pwm_o, 1'b1, "reset pwm");
    check("R1", ovf_irq_o, 1'b0, "reset irq");

    // R2, R5: mid duty at full rate, first value loaded by start (R8)
    start(1, 100, 0);
    push_window(100, 100, 0, 513, "R2");
    drain(); stop();

    // R4: duty 0, two transitions per period
    start(1, 0, 0);
    edges = 0; mon_first = 1'b1;
    push_window(0, 0, 0, 513, "R4");
    drain();
    total++;
    if (edges != 4) begin
      bad++;
      $display("FAIL R4 transitions: actual=%0d expected=%0d", edges, 4);
    end
    stop();

    // R3: duty 255 stays high, irq still pulses
    start(1, 255, 0);
    push_window(255, 255, 0, 513, "R3");
    drain(); stop();

    // R6: prescale selects
    start(1, 64, 1);
    push_window(64, 64, 1, 520, "R6");
    drain(); stop();
    start(1, 200, 2);
    push_window(200, 200, 2, 1030, "R6");
    drain(); stop();
    start(1, 17, 3);
    push_window(17, 17, 3, 1030, "R6");
    drain(); stop();

    // R7: write in mid-period takes effect next period
    start(1, 50, 0);
    push_window(50, 180, 0, 600, "R7");
    repeat (10) @(posedge clk_i);
    #1 duty_we_i = 1'b1; duty_i = 8'd180;
    @(posedge clk_i); #1 duty_we_i = 1'b0;
    drain(); stop();

    // R9: stop while output low
    start(1, 10, 0);
    push_window(10, 10, 0, 100, "R2");
    drain();
    check("R9", pwm_o, 1'b0, "low before stop");
    stop();
    @(negedge clk_i);
    check("R9", pwm_o, 1'b1, "pwm after stop");
    // R8: writes while stopped have no effect on the output
    @(posedge clk_i); #1 duty_we_i = 1'b1; duty_i = 8'd30;
    @(posedge clk_i); #1 duty_we_i = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      check("R9", pwm_o, 1'b1, "pwm idle");
      check("R9", ovf_irq_o, 1'b0, "irq idle");
    end
    check("R8", pwm_o, 1'b1, "pwm after stopped write");
    // R8: restart uses value written while stopped; counter restarts at 0
    start(0, 0, 0);
    push_window(30, 30, 0, 513, "R8");
    drain(); stop();

    repeat (3) @(posedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule